// File: doc/BRIEF.md
# DMA Stream Status and Error Monitor

This block watches one DMA stream. It follows the stream's enable, counts the data items that the transfer engine reports as finished on the destination side, and raises a half-way flag and a completion flag. It also watches the engine's event strobes and the stream configuration for error conditions. Errors fall into three kinds: bus and address-protection faults, FIFO faults, and the repeated-write hazard of the no-FIFO (direct) path. All five flags are sticky and each one has its own interrupt enable. All of them feed a single interrupt line.

Software starts the stream by writing 1 to the enable and stops it by writing 0. The readable enable stays at 1 until the engine reports that it is idle, so software can poll it before it switches off the peripheral. If the memory burst cannot fit a whole number of times into the FIFO threshold, the stream is not started. The block raises the FIFO error flag and emits a one-cycle forced-disable strobe instead.

Top module: `dma_stream_monitor`

## Requirements
- R1: After reset, `flags`, `irq`, `en_rd` and `force_dis` are all 0.
- R2: Writing 1 (`sw_en_wr`=1 with `sw_en_val`=1) while the stream is off and the configuration is compatible sets `en_rd` after that edge and latches `xfer_len`. Writing 0 while it runs keeps `en_rd` at 1 until a clock edge that sees `eng_busy`=0; `en_rd` drops after that edge. Writes of 1 during stopping are ignored.
- R3: Flag bit 0 (half) sets on the `item_done` that brings the completed count to ceil(`xfer_len`/2).
- R4: Flag bit 1 (complete) sets on the `item_done` that brings the count to `xfer_len`. Later `item_done` strobes have no effect. `item_done` is ignored while `en_rd` is 0.
- R5: Flag bit 2 (transfer error) sets on `rd_bus_err` or `wr_bus_err` while `en_rd` is 1. Both are ignored while `en_rd` is 0.
- R6: Bit 2 also sets on `addr0_wr` when `dbl_buf`=1, `en_rd`=1 and `cur_tgt`=0. It also sets on `addr1_wr` under the same conditions with `cur_tgt`=1. A write to the register that is not the current target does not set it.
- R7: Flag bit 3 (FIFO error) sets on `fifo_under` while enabled. It sets on `fifo_over` while enabled unless `dir_sel[1]`=1 (memory-to-memory). Direction codes are 00 peripheral-to-memory and 01 memory-to-peripheral.
- R8: On an enable write while off with `direct_mode`=0, the burst bytes are computed as (1, 2 or 4 bytes for `mem_size` 0, 1, 2 or higher) × (1, 4, 8 or 16 beats for `burst_sel` 0 to 3). The threshold bytes are 4 × (`fifo_thr`+1). If the burst bytes do not divide the threshold bytes, the stream stays off, bit 3 sets and `force_dis` pulses for one cycle after that edge.
- R9: Flag bit 4 (direct-mode error) sets only with `dir_sel`=00, `direct_mode`=1 and `mem_inc`=0, on a `per_req` in a cycle that starts with at least one item pending. Pending rises on `per_req` and falls on `mem_gnt`, saturating at 0 and at `OVR_LIM`.
- R10: In direct mode with direction 00, a `per_req` with `OVR_LIM` items pending sets bit 3 (overrun). With direction 01, the counter rises on `mem_gnt` and falls on `per_req`, and a `per_req` with no fetched item sets bit 3 (underrun).
- R11: A flag clears only when the matching `flag_clr` bit is 1. A set event in the same cycle wins over the clear.
- R12: `irq` is 1 exactly when some flag bit is 1 together with the same bit of `irq_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw_en_wr | input | 1 | Software write strobe for the enable |
| sw_en_val | input | 1 | Value written to the enable |
| xfer_len | input | CNT_W | Programmed item count |
| dir_sel | input | 2 | 00 periph-to-mem, 01 mem-to-periph, 1x mem-to-mem |
| direct_mode | input | 1 | FIFO bypass mode |
| mem_inc | input | 1 | Memory address increments |
| dbl_buf | input | 1 | Double-buffer mode |
| cur_tgt | input | 1 | Current target memory (0 or 1) |
| fifo_thr | input | 2 | FIFO threshold: quarter, half, three-quarter, full |
| burst_sel | input | 2 | Memory burst: single, 4, 8, 16 beats |
| mem_size | input | 2 | Memory item size: byte, half-word, word |
| eng_busy | input | 1 | Engine still moving data |
| item_done | input | 1 | One item finished on the destination port |
| rd_bus_err | input | 1 | Bus error on a read access |
| wr_bus_err | input | 1 | Bus error on a write access |
| fifo_under | input | 1 | FIFO underrun from the engine |
| fifo_over | input | 1 | FIFO overrun from the engine |
| per_req | input | 1 | Peripheral request |
| mem_gnt | input | 1 | Memory bus granted for one item |
| addr0_wr | input | 1 | Software write to memory address register 0 |
| addr1_wr | input | 1 | Software write to memory address register 1 |
| flag_clr | input | 5 | Write-one-to-clear per flag |
| irq_en | input | 5 | Per-flag interrupt enable |
| flags | output | 5 | {direct err, FIFO err, transfer err, complete, half} |
| irq | output | 1 | Interrupt |
| en_rd | output | 1 | Enable as seen by software |
| force_dis | output | 1 | One-cycle forced-disable strobe |

## Verification
The bench builds the block with `CNT_W`=8 and `OVR_LIM`=2. The small count width keeps the transfer lengths short, so half and complete marks, odd-length rounding and the ignored extra completions all occur within a few cycles. An overrun limit of 2 places the direct-mode error and the overrun one request apart, so both are seen in a single request sequence. The same limit also shows that the direct-mode error is not raised when the memory address increments.

// File: rtl/dma_stream_monitor.sv
module dma_stream_monitor #(
  parameter int CNT_W   = 16,
  parameter int OVR_LIM = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sw_en_wr,
  input  logic             sw_en_val,
  input  logic [CNT_W-1:0] xfer_len,
  input  logic [1:0]       dir_sel,
  input  logic             direct_mode,
  input  logic             mem_inc,
  input  logic             dbl_buf,
  input  logic             cur_tgt,
  input  logic [1:0]       fifo_thr,
  input  logic [1:0]       burst_sel,
  input  logic [1:0]       mem_size,
  input  logic             eng_busy,
  input  logic             item_done,
  input  logic             rd_bus_err,
  input  logic             wr_bus_err,
  input  logic             fifo_under,
  input  logic             fifo_over,
  input  logic             per_req,
  input  logic             mem_gnt,
  input  logic             addr0_wr,
  input  logic             addr1_wr,
  input  logic [4:0]       flag_clr,
  input  logic [4:0]       irq_en,
  output logic [4:0]       flags,
  output logic             irq,
  output logic             en_rd,
  output logic             force_dis
);

  localparam int PW = $clog2(OVR_LIM + 1);
  localparam logic [1:0] S_OFF = 2'd0, S_RUN = 2'd1, S_STOP = 2'd2;
  localparam logic [PW-1:0] PC_MAX = PW'(OVR_LIM);

  logic [1:0]       state;
  logic [CNT_W-1:0] done_cnt, len_q;
  logic [PW-1:0]    pend;
  logic             active, start, incompat;

  assign active = (state != S_OFF);
  assign en_rd  = active;
  assign start  = sw_en_wr && sw_en_val && (state == S_OFF);

  logic [2:0] size_log, beat_log, burst_log;
  logic [6:0] thr_bytes, burst_mask;
  assign size_log   = (mem_size == 2'd0) ? 3'd0 : (mem_size == 2'd1) ? 3'd1 : 3'd2;
  assign beat_log   = (burst_sel == 2'd0) ? 3'd0 : (burst_sel == 2'd1) ? 3'd2 :
                      (burst_sel == 2'd2) ? 3'd3 : 3'd4;
  assign burst_log  = size_log + beat_log;
  assign thr_bytes  = {3'd0, ({2'b00, fifo_thr} + 4'd1), 2'b00} >> 2 << 2;
  assign burst_mask = (7'd1 << burst_log) - 7'd1;
  assign incompat   = !direct_mode && ((thr_bytes & burst_mask) != 7'd0);

  logic [CNT_W:0] cnt_inc, half_mark;
  logic           item_ok, set_ht, set_tc;
  assign cnt_inc   = {1'b0, done_cnt} + 1'b1;
  assign half_mark = ({1'b0, len_q} + 1'b1) >> 1;
  assign item_ok   = active && item_done && (done_cnt < len_q);
  assign set_ht    = item_ok && (cnt_inc == half_mark);
  assign set_tc    = item_ok && (cnt_inc == {1'b0, len_q});

  logic dm_on, p2m, m2p, up, dn, dm_err, dm_ovr, dm_und;
  assign p2m    = (dir_sel == 2'b00);
  assign m2p    = (dir_sel == 2'b01);
  assign dm_on  = active && direct_mode && (p2m || m2p);
  assign up     = p2m ? per_req : mem_gnt;
  assign dn     = p2m ? mem_gnt : per_req;
  assign dm_err = dm_on && p2m && !mem_inc && per_req && (pend != '0);
  assign dm_ovr = dm_on && p2m && per_req && (pend == PC_MAX);
  assign dm_und = dm_on && m2p && per_req && (pend == '0);

  logic set_te, set_fe;
  logic [4:0] set_vec;
  assign set_te = active && (rd_bus_err || wr_bus_err ||
                  (dbl_buf && ((addr0_wr && !cur_tgt) || (addr1_wr && cur_tgt))));
  assign set_fe = (start && incompat) || dm_ovr || dm_und ||
                  (active && (fifo_under || (fifo_over && !dir_sel[1])));
  assign set_vec = {dm_err, set_fe, set_te, set_tc, set_ht};

  assign irq = |(flags & irq_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= S_OFF;
      done_cnt  <= '0;
      len_q     <= '0;
      pend      <= '0;
      flags     <= '0;
      force_dis <= 1'b0;
    end else begin
      flags     <= (flags & ~flag_clr) | set_vec;
      force_dis <= start && incompat;
      if (item_ok) done_cnt <= cnt_inc[CNT_W-1:0];
      if (dm_on) begin
        if (up && !dn && pend != PC_MAX) pend <= pend + 1'b1;
        else if (dn && !up && pend != '0) pend <= pend - 1'b1;
      end
      case (state)
        S_OFF:
          if (start && !incompat) begin
            state    <= S_RUN;
            len_q    <= xfer_len;
            done_cnt <= '0;
            pend     <= '0;
          end
        S_RUN:
          if (sw_en_wr && !sw_en_val) state <= S_STOP;
        default:
          if (!eng_busy) state <= S_OFF;
      endcase
    end
  end

endmodule

module dma_stream_monitor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [4:0] flags,
  input logic       en_rd,
  input logic       force_dis,
  input logic       eng_busy,
  input logic [4:0] flag_clr,
  input logic [1:0] dir_sel,
  input logic       direct_mode,
  input logic       mem_inc
);

  AST_FORCE_STAYS_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    force_dis |-> !en_rd); // R8

  AST_FORCE_RAISES_FE: assert property (@(posedge clk) disable iff (!rst_n)
    force_dis |-> flags[3]); // R8

  AST_EN_DROPS_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_rd) |-> !$past(eng_busy)); // R2

  AST_DME_ONLY_IN_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flags[4]) |-> $past(dir_sel == 2'b00 && direct_mode && !mem_inc)); // R9

  for (genvar b = 0; b < 5; b++) begin : g_sticky
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(flags[b]) |-> $past(flag_clr[b])); // R11
  end

endmodule

bind dma_stream_monitor dma_stream_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .flags(flags), .en_rd(en_rd), .force_dis(force_dis),
  .eng_busy(eng_busy), .flag_clr(flag_clr), .dir_sel(dir_sel),
  .direct_mode(direct_mode), .mem_inc(mem_inc)
);

// File: tb/test_dma_stream_monitor.sv
`timescale 1ns/1ps
module test_dma_stream_monitor;
  localparam int CW = 8;
  localparam int LIM = 2;

  logic clk = 0, rst_n = 0;
  logic sw_en_wr = 0, sw_en_val = 0;
  logic [CW-1:0] xfer_len = 8'd5;
  logic [1:0] dir_sel = 0, fifo_thr = 2'd3, burst_sel = 0, mem_size = 2'd2;
  logic direct_mode = 0, mem_inc = 1, dbl_buf = 0, cur_tgt = 0;
  logic eng_busy = 0, item_done = 0, rd_bus_err = 0, wr_bus_err = 0;
  logic fifo_under = 0, fifo_over = 0, per_req = 0, mem_gnt = 0;
  logic addr0_wr = 0, addr1_wr = 0;
  logic [4:0] flag_clr = 0, irq_en = 0;
  logic [4:0] flags;
  logic irq, en_rd, force_dis;

  always #4 clk = ~clk;

  dma_stream_monitor #(.CNT_W(CW), .OVR_LIM(LIM)) i_dma_stream_monitor (
    .clk(clk), .rst_n(rst_n), .sw_en_wr(sw_en_wr), .sw_en_val(sw_en_val),
    .xfer_len(xfer_len), .dir_sel(dir_sel), .direct_mode(direct_mode),
    .mem_inc(mem_inc), .dbl_buf(dbl_buf), .cur_tgt(cur_tgt), .fifo_thr(fifo_thr),
    .burst_sel(burst_sel), .mem_size(mem_size), .eng_busy(eng_busy),
    .item_done(item_done), .rd_bus_err(rd_bus_err), .wr_bus_err(wr_bus_err),
    .fifo_under(fifo_under), .fifo_over(fifo_over), .per_req(per_req),
    .mem_gnt(mem_gnt), .addr0_wr(addr0_wr), .addr1_wr(addr1_wr),
    .flag_clr(flag_clr), .irq_en(irq_en), .flags(flags), .irq(irq),
    .en_rd(en_rd), .force_dis(force_dis));

  int checks = 0, fails = 0;
  string cur_req = "R1";

  // behavioural reference model
  int m_state = 0, m_cnt = 0, m_len = 0, m_pend = 0;
  bit [4:0] m_flags = 0;
  bit m_force = 0;
  bit m_ready = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_cnt = 0; m_len = 0; m_pend = 0; m_flags = 0; m_force = 0;
    end else begin
      bit [4:0] s;
      int nst, thr, burst, beats, delta;
      bit act, bad;
      s = 0; act = (m_state != 0); nst = m_state;
      beats = (burst_sel == 0) ? 1 : (burst_sel == 1) ? 4 : (burst_sel == 2) ? 8 : 16;
      burst = beats * ((mem_size == 0) ? 1 : (mem_size == 1) ? 2 : 4);
      thr = 4 * (int'(fifo_thr) + 1);
      bad = !direct_mode && ((thr % burst) != 0);
      m_force = 0;
      if (act && item_done && m_cnt < m_len) begin
        m_cnt++;
        if (m_cnt == (m_len + 1) / 2) s[0] = 1;
        if (m_cnt == m_len) s[1] = 1;
      end
      if (act && (rd_bus_err || wr_bus_err)) s[2] = 1;
      if (act && dbl_buf && ((addr0_wr && cur_tgt == 0) || (addr1_wr && cur_tgt == 1))) s[2] = 1;
      if (act && fifo_under) s[3] = 1;
      if (act && fifo_over && dir_sel < 2) s[3] = 1;
      if (act && direct_mode && dir_sel < 2) begin
        if (dir_sel == 0) begin
          if (per_req && !mem_inc && m_pend > 0) s[4] = 1;
          if (per_req && m_pend == LIM) s[3] = 1;
          delta = int'(per_req) - int'(mem_gnt);
        end else begin
          if (per_req && m_pend == 0) s[3] = 1;
          delta = int'(mem_gnt) - int'(per_req);
        end
        m_pend = m_pend + delta;
        if (m_pend < 0) m_pend = 0;
        if (m_pend > LIM) m_pend = LIM;
      end
      if (m_state == 0 && sw_en_wr && sw_en_val) begin
        if (bad) begin s[3] = 1; m_force = 1; end
        else begin nst = 1; m_len = int'(xfer_len); m_cnt = 0; m_pend = 0; end
      end else if (m_state == 1 && sw_en_wr && !sw_en_val) nst = 2;
      else if (m_state == 2 && !eng_busy) nst = 0;
      m_state = nst;
      m_flags = (m_flags & ~flag_clr) | s;
    end
  end

  always @(posedge clk) begin
    #2;
    m_ready = 1;
    checks += 4;
    if (flags !== m_flags) begin fails++; $display("FAIL %s flags act=%b exp=%b", cur_req, flags, m_flags); end
    if (en_rd !== (m_state != 0)) begin fails++; $display("FAIL %s en_rd act=%b exp=%b", cur_req, en_rd, m_state != 0); end
    if (force_dis !== m_force) begin fails++; $display("FAIL %s force_dis act=%b exp=%b", cur_req, force_dis, m_force); end
    if (irq !== |(m_flags & irq_en)) begin fails++; $display("FAIL %s irq act=%b exp=%b", cur_req, irq, |(m_flags & irq_en)); end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin fails++; $display("FAIL %s act=%0h exp=%0h", tag, act, exp); end
  endtask

  task automatic tick(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic en_write(input logic v);
    sw_en_wr = 1; sw_en_val = v; tick(); sw_en_wr = 0;
  endtask

  task automatic clear(input logic [4:0] m);
    flag_clr = m; tick(); flag_clr = 0;
  endtask

  initial begin
    #(8 * 200000);
    fails++;
    $display("FAIL watchdog act=running exp=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    tick(3); rst_n = 1; tick();
    cur_req = "R1";
    chk("R1 flags", flags, 0); chk("R1 en_rd", en_rd, 0);
    chk("R1 irq", irq, 0); chk("R1 force", force_dis, 0);

    cur_req = "R8";
    burst_sel = 1; fifo_thr = 0;           // 16-byte burst vs 4-byte threshold
    en_write(1);
    chk("R8 force_dis", force_dis, 1); chk("R8 en_rd", en_rd, 0); chk("R8 fe", flags[3], 1);
    tick(); chk("R8 strobe one cycle", force_dis, 0);
    cur_req = "R11"; clear(5'b01000); chk("R11 cleared", flags, 0);

    cur_req = "R2"; fifo_thr = 3;          // 16-byte threshold fits
    en_write(1); chk("R2 running", en_rd, 1); chk("R8 compatible no strobe", force_dis, 0);

    cur_req = "R3"; irq_en = 5'b00011;
    item_done = 1; tick(2); item_done = 0;
    chk("R3 not yet half", flags[0], 0);
    item_done = 1; tick(); item_done = 0;
    chk("R3 half at 3 of 5", flags[0], 1); chk("R12 irq half", irq, 1);
    cur_req = "R4";
    item_done = 1; tick(); chk("R4 not complete at 4", flags[1], 0);
    tick(); chk("R4 complete", flags[1], 1);
    tick(2); item_done = 0;
    chk("R4 extra ignored", flags, 5'b00011);

    cur_req = "R12"; irq_en = 5'b11100; tick();
    chk("R12 masked", irq, 0);
    cur_req = "R5"; rd_bus_err = 1; tick(); rd_bus_err = 0;
    chk("R5 read err", flags[2], 1); chk("R12 irq te", irq, 1);
    clear(5'b00100);
    wr_bus_err = 1; tick(); wr_bus_err = 0;
    chk("R5 write err", flags[2], 1);

    cur_req = "R11";
    wr_bus_err = 1; flag_clr = 5'b00100; tick(); wr_bus_err = 0; flag_clr = 0;
    chk("R11 set wins", flags[2], 1);
    clear(5'b00100); chk("R11 clear", flags[2], 0);

    cur_req = "R6"; dbl_buf = 1; cur_tgt = 1;
    addr0_wr = 1; tick(); addr0_wr = 0; chk("R6 other reg", flags[2], 0);
    addr1_wr = 1; tick(); addr1_wr = 0; chk("R6 target reg", flags[2], 1);
    clear(5'b00100); dbl_buf = 0;
    addr1_wr = 1; tick(); addr1_wr = 0; chk("R6 no dbuf", flags[2], 0);

    cur_req = "R7";
    fifo_under = 1; tick(); fifo_under = 0; chk("R7 underrun", flags[3], 1);
    clear(5'b01000);
    dir_sel = 2; fifo_over = 1; tick(); fifo_over = 0; chk("R7 m2m overrun ignored", flags[3], 0);
    dir_sel = 0; fifo_over = 1; tick(); fifo_over = 0; chk("R7 overrun", flags[3], 1);
    clear(5'b11111);

    cur_req = "R2"; eng_busy = 1; en_write(0);
    tick(3); chk("R2 held while busy", en_rd, 1);
    en_write(1); chk("R2 write during stop ignored", en_rd, 1);
    eng_busy = 0; tick(); chk("R2 dropped", en_rd, 0);
    cur_req = "R5"; rd_bus_err = 1; tick(); rd_bus_err = 0; chk("R5 ignored when off", flags[2], 0);

    cur_req = "R9"; direct_mode = 1; mem_inc = 0; dir_sel = 0;
    en_write(1);
    per_req = 1; tick(); per_req = 0; chk("R9 first req", flags[4], 0);
    per_req = 1; tick(); per_req = 0; chk("R9 repeat", flags[4], 1);
    cur_req = "R10"; chk("R10 not yet over", flags[3], 0);
    per_req = 1; tick(); per_req = 0; chk("R10 overrun", flags[3], 1);
    clear(5'b11111);
    cur_req = "R9"; mem_gnt = 1; tick(3); mem_gnt = 0;
    mem_inc = 1; per_req = 1; tick(2); per_req = 0;
    chk("R9 minc on", flags[4], 0);
    mem_gnt = 1; tick(2); mem_gnt = 0;
    en_write(0); tick(2);

    cur_req = "R10"; dir_sel = 1;
    en_write(1);
    per_req = 1; tick(); per_req = 0; chk("R10 underrun", flags[3], 1);
    clear(5'b01000);
    mem_gnt = 1; tick(); mem_gnt = 0;
    per_req = 1; tick(); per_req = 0; chk("R10 fetched ok", flags[3], 0);
    irq_en = 5'b01000; tick(); chk("R12 no flag no irq", irq, 0);
    tick(2);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule